// File: doc/BRIEF.md
# Segment Privilege Check Unit

This unit guards memory accesses with a four-ring protection scheme. It keeps a small file of segment registers. Each register caches, at the moment a new selector is written into it, the requestor level carried in the selector and the privilege level and kind (code or data) of the descriptor that selector names. Later accesses through that register read this cached copy and never fetch the descriptor again. Ring 0 is the most privileged ring and ring 3 is the least privileged.

Each cycle the caller may present one access request. A request names a segment register, says whether it is a data access or a far call into code, and gives the current privilege level and the user/supervisor attribute of the target page. One cycle later the unit returns a single-cycle verdict: either a grant, or a fault with a two-bit cause code.

Requests and descriptor loads are accepted in every cycle. The unit applies no back-pressure, so there is no ready signal. Every request produces exactly one response in the next cycle, in request order. The descriptor fetch is modelled as the load port: the caller supplies the descriptor fields together with the selector.

Top module: `seg_priv_check`

## Requirements
- R1: While reset is held, and after it is released until the first request, `rsp_valid`, `rsp_grant` and `rsp_fault` are 0 and `rsp_code` is 00.
- R2: `rsp_valid` is 1 in the cycle after a cycle with `req_valid` = 1, and is 0 in the cycle after a cycle with `req_valid` = 0. Back-to-back requests each get their own response.
- R3: A data access (`req_call` = 0) to a loaded register is granted exactly when the cached DPL is numerically at least max(CPL, RPL), where RPL is bits 1:0 of the selector. Otherwise it faults with code 01. The descriptor kind does not affect data accesses.
- R4: A far call (`req_call` = 1) to a loaded register is granted exactly when the cached descriptor is code (`ld_code` was 1) and its DPL is numerically at most CPL. Otherwise it faults with code 10. RPL does not affect calls.
- R5: A request with `req_page_user` = 0 (supervisor page) and CPL = 3 faults with code 11. This page fault takes priority over every segment fault. A user page (`req_page_user` = 1) never causes a page fault.
- R6: A request through a register that has not been loaded since reset faults with code 01 for a data access and code 10 for a call, unless R5 applies.
- R7: A load updates the cache on the clock edge. A request in the same cycle as a load to the same register is judged with the old cached values. A request in the next cycle uses the new values.
- R8: `rsp_grant` and `rsp_fault` are never both 1. Either one is 1 only together with `rsp_valid`. `rsp_code` is 00 whenever `rsp_fault` is 0 and nonzero whenever `rsp_fault` is 1.
- R9: A load changes only the register it names. The other registers keep their cached values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears all responses and marks every register unloaded |
| ld_valid | input | 1 | Load a new selector and its descriptor this cycle |
| ld_idx | input | IDX_W | Segment register to load |
| ld_rpl | input | 2 | Bits 1:0 of the selector being loaded (requestor level) |
| ld_dpl | input | 2 | Privilege level of the fetched descriptor |
| ld_code | input | 1 | 1 when the fetched descriptor is a code segment |
| req_valid | input | 1 | An access request is present this cycle |
| req_idx | input | IDX_W | Segment register the access goes through |
| req_call | input | 1 | 1 for a far call into code, 0 for a data read or write |
| req_cpl | input | 2 | Current privilege level of the requester |
| req_page_user | input | 1 | 1 when the target page is a user page, 0 for supervisor |
| rsp_valid | output | 1 | A verdict is present this cycle |
| rsp_grant | output | 1 | The access is allowed |
| rsp_fault | output | 1 | Protection violation pulse |
| rsp_code | output | 2 | Fault cause: 01 data privilege, 10 call privilege, 11 page privilege |

## Verification
A corrupted cache entry cannot be seen until a request goes through that register. It then shows up in the very next cycle as a wrong verdict, but only for the CPL, access-kind and page combinations that sit on the far side of the altered field's threshold. A single probe can therefore miss it. The bench sweeps every selector level, descriptor level and descriptor kind into every register, and probes each one with all 16 request combinations. A lost valid bit, a swapped register index or a leaking write then appears within one load-and-probe round. Ordering bugs between the page check and the segment checks appear on the first supervisor-page request at ring 3 that also has a segment fault.

// File: rtl/seg_priv_pkg.sv
package seg_priv_pkg;
  localparam int PL_W = 2;
  localparam logic [PL_W-1:0] PL_LEAST = 2'd3;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_DATA = 2'b01,
    FLT_CALL = 2'b10,
    FLT_PAGE = 2'b11
  } fault_e;

  typedef struct packed {
    logic            valid;
    logic            is_code;
    logic [PL_W-1:0] rpl;
    logic [PL_W-1:0] dpl;
  } seg_entry_t;
endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_priv_pkg::*;
#(
  parameter int NSEG  = 4,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PL_W-1:0]  wr_rpl,
  input  logic [PL_W-1:0]  wr_dpl,
  input  logic             wr_code,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_entry_t       rd_ent
);
  seg_entry_t ents [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        ents[g].valid   <= 1'b1;
        ents[g].is_code <= wr_code;
        ents[g].rpl     <= wr_rpl;
        ents[g].dpl     <= wr_dpl;
      end
    end
  end

  always_comb begin
    rd_ent = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (rd_idx == IDX_W'(i)) rd_ent = ents[i];
    end
  end
endmodule

// File: rtl/seg_priv_eval.sv
module seg_priv_eval
  import seg_priv_pkg::*;
(
  input  seg_entry_t      ent,
  input  logic            is_call,
  input  logic [PL_W-1:0] cpl,
  input  logic            page_user,
  output fault_e          cause
);
  logic [PL_W-1:0] eff_pl;
  logic            page_bad;
  logic            data_ok;
  logic            call_ok;

  always_comb begin
    eff_pl   = (cpl > ent.rpl) ? cpl : ent.rpl;
    page_bad = !page_user && (cpl == PL_LEAST);
    data_ok  = ent.dpl >= eff_pl;
    call_ok  = ent.is_code && (ent.dpl <= cpl);
    if (page_bad)          cause = FLT_PAGE;
    else if (!ent.valid)   cause = is_call ? FLT_CALL : FLT_DATA;
    else if (is_call)      cause = call_ok ? FLT_NONE : FLT_CALL;
    else                   cause = data_ok ? FLT_NONE : FLT_DATA;
  end
endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
  import seg_priv_pkg::*;
#(
  parameter int NSEG  = 4,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [1:0]       ld_rpl,
  input  logic [1:0]       ld_dpl,
  input  logic             ld_code,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_call,
  input  logic [1:0]       req_cpl,
  input  logic             req_page_user,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic             rsp_fault,
  output logic [1:0]       rsp_code
);
  seg_entry_t sel_ent;
  fault_e     cause;
  fault_e     cause_q;

  seg_desc_cache #(.NSEG(NSEG)) u_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_valid),
    .wr_idx  (ld_idx),
    .wr_rpl  (ld_rpl),
    .wr_dpl  (ld_dpl),
    .wr_code (ld_code),
    .rd_idx  (req_idx),
    .rd_ent  (sel_ent)
  );

  seg_priv_eval u_eval (
    .ent       (sel_ent),
    .is_call   (req_call),
    .cpl       (req_cpl),
    .page_user (req_page_user),
    .cause     (cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      cause_q   <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      cause_q   <= req_valid ? cause : FLT_NONE;
    end
  end

  assign rsp_code  = cause_q;
  assign rsp_fault = rsp_valid && (cause_q != FLT_NONE);
  assign rsp_grant = rsp_valid && (cause_q == FLT_NONE);
endmodule

// File: rtl/seg_priv_check_sva.sv
module seg_priv_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_cpl,
  input logic       req_page_user,
  input logic       rsp_valid,
  input logic       rsp_grant,
  input logic       rsp_fault,
  input logic [1:0] rsp_code
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_page_user && req_cpl == 2'd3) |=> (rsp_fault && rsp_code == 2'b11)); // R5
  AST_USER_NO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_page_user) |=> (rsp_code != 2'b11)); // R5
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_grant && rsp_fault)); // R8
  AST_VERDICT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_grant || rsp_fault) |-> rsp_valid); // R8
  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault == (rsp_code != 2'b00)); // R8
  AST_IDLE_AT_RESET: assert property (@(posedge clk)
    !rst_n |-> (!rsp_valid && rsp_code == 2'b00)); // R1
endmodule

bind seg_priv_check seg_priv_check_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_cpl       (req_cpl),
  .req_page_user (req_page_user),
  .rsp_valid     (rsp_valid),
  .rsp_grant     (rsp_grant),
  .rsp_fault     (rsp_fault),
  .rsp_code      (rsp_code)
);

// File: tb/seg_priv_check_tb.sv
module seg_priv_check_tb;
  localparam int NSEG  = 4;
  localparam int IDX_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ld_valid = 1'b0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [1:0]       ld_rpl = '0;
  logic [1:0]       ld_dpl = '0;
  logic             ld_code = 1'b0;
  logic             req_valid = 1'b0;
  logic [IDX_W-1:0] req_idx = '0;
  logic             req_call = 1'b0;
  logic [1:0]       req_cpl = '0;
  logic             req_page_user = 1'b1;
  logic             rsp_valid, rsp_grant, rsp_fault;
  logic [1:0]       rsp_code;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_priv_check #(.NSEG(NSEG)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_rpl(ld_rpl), .ld_dpl(ld_dpl), .ld_code(ld_code),
    .req_valid(req_valid), .req_idx(req_idx), .req_call(req_call), .req_cpl(req_cpl),
    .req_page_user(req_page_user),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .rsp_code(rsp_code)
  );

  function automatic logic [1:0] expect_code(input logic loaded, input logic [1:0] rpl,
      input logic [1:0] dpl, input logic is_code, input logic call,
      input logic [1:0] cpl, input logic pu);
    int eff;
    eff = (int'(cpl) > int'(rpl)) ? int'(cpl) : int'(rpl);
    if (!pu && cpl == 2'd3) return 2'b11;
    if (!loaded) return call ? 2'b10 : 2'b01;
    if (call) return (is_code && int'(dpl) <= int'(cpl)) ? 2'b00 : 2'b10;
    return (int'(dpl) >= eff) ? 2'b00 : 2'b01;
  endfunction

  task automatic check_rsp(input string tag, input logic [1:0] exp);
    logic [4:0] act, want;
    act  = {rsp_valid, rsp_grant, rsp_fault, rsp_code};
    want = {1'b1, exp == 2'b00, exp != 2'b00, exp};
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s: valid/grant/fault/code actual=%b expected=%b", tag, act, want);
    end
  endtask

  // Called at a negedge; drives the request, checks at the following negedge.
  task automatic probe(input string tag, input logic [1:0] idx, input logic call,
                       input logic [1:0] cpl, input logic pu, input logic [1:0] exp);
    req_valid = 1'b1; req_idx = idx; req_call = call; req_cpl = cpl; req_page_user = pu;
    @(negedge clk);
    ld_valid = 1'b0;
    check_rsp(tag, exp);
  endtask

  task automatic load(input logic [1:0] idx, input logic [1:0] rpl,
                      input logic [1:0] dpl, input logic code);
    ld_valid = 1'b1; ld_idx = idx; ld_rpl = rpl; ld_dpl = dpl; ld_code = code;
    req_valid = 1'b0;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    checks++; // R1 during reset
    if ({rsp_valid, rsp_grant, rsp_fault, rsp_code} !== 5'b0) begin
      errors++;
      $display("FAIL R1: actual=%b expected=00000", {rsp_valid, rsp_grant, rsp_fault, rsp_code});
    end
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    checks++; // R1 after release
    if ({rsp_valid, rsp_grant, rsp_fault, rsp_code} !== 5'b0) begin
      errors++;
      $display("FAIL R1 idle: actual=%b expected=00000", {rsp_valid, rsp_grant, rsp_fault, rsp_code});
    end

    // R6: unloaded registers, R5 priority over them
    for (int i = 0; i < NSEG; i++) begin
      probe("R6 unloaded data", 2'(i), 1'b0, 2'd0, 1'b1, 2'b01);
      probe("R6 unloaded call", 2'(i), 1'b1, 2'd0, 1'b1, 2'b10);
      probe("R5 page over unloaded", 2'(i), 1'b1, 2'd3, 1'b0, 2'b11);
    end
    req_valid = 1'b0;
    @(negedge clk);
    checks++; // R2 idle cycle gives no response
    if (rsp_valid !== 1'b0 || rsp_grant !== 1'b0 || rsp_fault !== 1'b0) begin
      errors++;
      $display("FAIL R2: valid/grant/fault actual=%b%b%b expected=000", rsp_valid, rsp_grant, rsp_fault);
    end

    // R3/R4/R5 sweep: every selector/descriptor combination in every register
    for (int c = 0; c < 32; c++) begin
      for (int i = 0; i < NSEG; i++) begin
        logic [1:0] rpl, dpl;
        logic       cd;
        rpl = 2'(c); dpl = 2'(c >> 2); cd = c[4];
        load(2'(i), rpl, dpl, cd);
        for (int q = 0; q < 16; q++) begin
          logic [1:0] cpl;
          logic       call, pu;
          cpl = 2'(q); call = q[2]; pu = q[3];
          probe(call ? "R4 call sweep" : "R3 data sweep", 2'(i), call, cpl, pu,
                expect_code(1'b1, rpl, dpl, cd, call, cpl, pu));
        end
      end
    end

    // R9: loading other registers leaves register 2 intact
    load(2'd2, 2'd0, 2'd0, 1'b1);
    load(2'd3, 2'd3, 2'd3, 1'b0);
    load(2'd1, 2'd3, 2'd3, 1'b0);
    probe("R9 neighbour kept (call)", 2'd2, 1'b1, 2'd0, 1'b1, 2'b00);
    probe("R9 neighbour kept (data)", 2'd2, 1'b0, 2'd1, 1'b1, 2'b01);

    // R7: same-cycle load sees old values; next cycle sees new
    ld_valid = 1'b1; ld_idx = 2'd1; ld_rpl = 2'd0; ld_dpl = 2'd0; ld_code = 1'b0;
    probe("R7 old values same cycle", 2'd1, 1'b0, 2'd3, 1'b1, 2'b00);
    probe("R7 new values next cycle", 2'd1, 1'b0, 2'd3, 1'b1, 2'b01);
    req_valid = 1'b0;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule